// File: doc/BRIEF.md
# Two-Channel Serial Audio Word Deserializer

This block turns a serial stereo audio stream into parallel sample pairs. It runs on the serial bit clock and samples a data line and a frame-select line on every rising edge. While the frame-select line is high, the current slot belongs to channel 1. While it is low, the slot belongs to channel 2. From each slot the block keeps one 16-bit two's-complement word. Once a complete channel 1 / channel 2 pair has been received, it presents both words together and marks them with a single-cycle strobe.

Three static format inputs adapt the block to the transmitter. The first chooses a slot of 24 or 32 bit periods. The second places the 16-bit word at the front or the tail of the slot. The third chooses whether the word arrives most-significant bit first or least-significant bit first. If a slot is not exactly the configured length, the block drops that pair and pulses an error flag in its place. A synchronous active-low clear returns all capture state to idle.

Top module: `aud_deser_rx`

## Requirements
- R1: While `clr_n` is low at a rising `clk` edge, `ch1_word` and `ch2_word` become 0 and `pair_valid` and `frame_err` are low. After clear, the slot in progress and a channel 2 slot that has no channel 1 slot before it produce neither a strobe nor an error.
- R2: A slot sampled with `lrclk` = 1 supplies `ch1_word`, and a slot sampled with `lrclk` = 0 supplies `ch2_word`.
- R3: `sdata` and `lrclk` are sampled on the rising edge of `clk`. A slot begins at the first sample whose `lrclk` differs from the previous sample, and that sample is bit index 0 of the slot.
- R4: `long_slot` = 1 sets the expected slot length to 32 bit periods, and `long_slot` = 0 sets it to 24.
- R5: `tail_win` = 0 keeps bit indices 0 to 15 of a slot, and `tail_win` = 1 keeps indices L-16 to L-1, where L is the configured slot length. Bits outside the kept window have no effect on the outputs.
- R6: With `msb_first` = 1, the first kept bit is bit 15 of the word. With `msb_first` = 0, the first kept bit is bit 0.
- R7: `ch1_word` and `ch2_word` update together, and `pair_valid` is high for exactly one cycle, on the clock edge that samples bit 0 of the channel 1 slot following a completed pair. At all other times the words hold their values.
- R8: If the channel 1 slot or the channel 2 slot of a pair has a length other than the configured one, the words stay unchanged, no strobe is given, and `frame_err` pulses for one cycle at the point where the strobe would have come. The next well-formed pair is delivered normally.
- R9: `pair_valid` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| lrclk | input | 1 | Frame select: 1 = channel 1 slot, 0 = channel 2 slot |
| sdata | input | 1 | Serial sample data |
| long_slot | input | 1 | 1 = 32-bit slots, 0 = 24-bit slots |
| tail_win | input | 1 | 1 = word in last 16 bits of slot, 0 = first 16 bits |
| msb_first | input | 1 | 1 = MSB arrives first, 0 = LSB arrives first |
| ch1_word | output | 16 | Channel 1 sample, two's complement |
| ch2_word | output | 16 | Channel 2 sample, two's complement |
| pair_valid | output | 1 | One-cycle strobe: a new pair is on the outputs |
| frame_err | output | 1 | One-cycle flag: a pair was dropped for a length mismatch |

## Verification
The embedded properties check the following on every cycle. The strobe and the error flag never coincide, and each lasts a single cycle. Both fire only right after `lrclk` rises. The words never move without the strobe. Any delivered pair had a slot of the configured length, and every correct-length slot fed exactly sixteen bits into the shifter. What the properties cannot show is whether the bits land in the right positions. The bench sweeps all eight format combinations, with edge-case words and arithmetically generated words, filler bits outside the window, both startup phases, and short and long slots. Those scenarios alone show the correct window placement, bit order, channel assignment and startup suppression.

// File: rtl/aud_deser_pkg.sv
package aud_deser_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int LONG_SLOT  = 32;
    localparam int SHORT_SLOT = 24;
    localparam int CNT_W      = $clog2(LONG_SLOT + 2);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CNT_W-1:0]    bitcnt_t;

    typedef struct packed {
        logic long_slot;
        logic tail_win;
        logic msb_first;
    } fmt_t;

    typedef struct packed {
        logic    start;      // this sample opens a new slot
        bitcnt_t idx;        // bit index of this sample in its slot
        bitcnt_t prev_len;   // bits counted in the slot that just ended
        logic    prev_ch1;   // the slot that just ended was channel 1
        logic    prev_live;  // the slot that just ended began after clear
    } slot_info_t;

    function automatic bitcnt_t slot_len(fmt_t f);
        return f.long_slot ? bitcnt_t'(LONG_SLOT) : bitcnt_t'(SHORT_SLOT);
    endfunction

    function automatic bitcnt_t win_start(fmt_t f);
        return f.tail_win ? bitcnt_t'(slot_len(f) - bitcnt_t'(SAMPLE_W)) : '0;
    endfunction
endpackage

// File: rtl/aud_slot_tracker.sv
module aud_slot_tracker
    import aud_deser_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       lrclk,
    output slot_info_t info
);
    logic    lr_q;
    bitcnt_t cnt;
    logic    live;
    logic    slot_edge;

    assign slot_edge = (lrclk != lr_q);

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            lr_q <= lrclk;
            cnt  <= '0;
            live <= 1'b0;
        end else begin
            lr_q <= lrclk;
            if (slot_edge) begin
                cnt  <= bitcnt_t'(1);
                live <= 1'b1;
            end else if (cnt != '1) begin
                cnt <= cnt + bitcnt_t'(1);
            end
        end
    end

    always_comb begin
        info.start     = slot_edge;
        info.idx       = slot_edge ? '0 : cnt;
        info.prev_len  = cnt;
        info.prev_ch1  = lr_q;
        info.prev_live = live;
    end

    // R3: the sample after a slot edge is bit index 1
    assert_slot_restart_R3: assert property (@(posedge clk) disable iff (!clr_n)
        info.start |=> (info.start || info.idx == bitcnt_t'(1)));
endmodule

// File: rtl/aud_word_shifter.sv
module aud_word_shifter
    import aud_deser_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  fmt_t       fmt,
    input  slot_info_t info,
    input  logic       sdata,
    output sample_t    word
);
    logic [CNT_W:0] ws;
    logic [CNT_W:0] we;
    logic           in_win;

    always_comb begin
        ws     = {1'b0, win_start(fmt)};
        we     = ws + (CNT_W+1)'(SAMPLE_W);
        in_win = ({1'b0, info.idx} >= ws) && ({1'b0, info.idx} < we);
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            word <= '0;
        end else if (in_win) begin
            if (fmt.msb_first) word <= {word[SAMPLE_W-2:0], sdata};
            else               word <= {sdata, word[SAMPLE_W-1:1]};
        end
    end

    // checker counter: bits taken into the shifter during the current slot
    bitcnt_t taken;
    always_ff @(posedge clk) begin
        if (!clr_n)          taken <= '0;
        else if (info.start) taken <= bitcnt_t'(in_win);
        else if (in_win)     taken <= taken + bitcnt_t'(1);
    end

    // R5: a slot of the configured length feeds exactly one word's worth of bits
    assert_window_bits_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (info.start && info.prev_live && info.prev_len == slot_len(fmt))
            |-> taken == bitcnt_t'(SAMPLE_W));
endmodule

// File: rtl/aud_frame_assembler.sv
module aud_frame_assembler
    import aud_deser_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  fmt_t       fmt,
    input  slot_info_t info,
    input  sample_t    word,
    output sample_t    ch1_word,
    output sample_t    ch2_word,
    output logic       pair_valid,
    output logic       frame_err
);
    sample_t hold1;
    logic    have1;
    logic    ok1;
    logic    len_ok;
    logic    slot_done;

    assign len_ok    = (info.prev_len == slot_len(fmt));
    assign slot_done = info.start && info.prev_live;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            hold1      <= '0;
            have1      <= 1'b0;
            ok1        <= 1'b0;
            ch1_word   <= '0;
            ch2_word   <= '0;
            pair_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (slot_done) begin
                if (info.prev_ch1) begin
                    hold1 <= word;
                    have1 <= 1'b1;
                    ok1   <= len_ok;
                end else if (have1) begin
                    have1 <= 1'b0;
                    if (ok1 && len_ok) begin
                        ch1_word   <= hold1;
                        ch2_word   <= word;
                        pair_valid <= 1'b1;
                    end else begin
                        frame_err <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: a delivered pair closed on a slot of the configured length
    assert_len_match_R8: assert property (@(posedge clk) disable iff (!clr_n)
        pair_valid |-> $past(info.prev_len) == $past(slot_len(fmt)));
    // R9: strobe and error are exclusive
    assert_excl_flags_R9: assert property (@(posedge clk) disable iff (!clr_n)
        !(pair_valid && frame_err));
endmodule

// File: rtl/aud_deser_rx.sv
module aud_deser_rx
    import aud_deser_pkg::*;
(
    input  logic                clk,
    input  logic                clr_n,
    input  logic                lrclk,
    input  logic                sdata,
    input  logic                long_slot,
    input  logic                tail_win,
    input  logic                msb_first,
    output logic [SAMPLE_W-1:0] ch1_word,
    output logic [SAMPLE_W-1:0] ch2_word,
    output logic                pair_valid,
    output logic                frame_err
);
    fmt_t       fmt;
    slot_info_t info;
    sample_t    word;

    assign fmt = '{long_slot: long_slot, tail_win: tail_win, msb_first: msb_first};

    aud_slot_tracker u_track (
        .clk   (clk),
        .clr_n (clr_n),
        .lrclk (lrclk),
        .info  (info)
    );

    aud_word_shifter u_shift (
        .clk   (clk),
        .clr_n (clr_n),
        .fmt   (fmt),
        .info  (info),
        .sdata (sdata),
        .word  (word)
    );

    aud_frame_assembler u_asm (
        .clk        (clk),
        .clr_n      (clr_n),
        .fmt        (fmt),
        .info       (info),
        .word       (word),
        .ch1_word   (ch1_word),
        .ch2_word   (ch2_word),
        .pair_valid (pair_valid),
        .frame_err  (frame_err)
    );

    // R7: strobe lasts one cycle
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!clr_n)
        pair_valid |=> !pair_valid);
    // R7: words move only with the strobe
    assert_words_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
        !pair_valid |-> ($stable(ch1_word) && $stable(ch2_word)));
    // R2: results appear only right after the frame select rises (start of channel 1)
    assert_after_rise_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (pair_valid || frame_err) |-> ($past(lrclk) && !$past(lrclk, 2)));
    // R8: the error flag is a single-cycle pulse
    assert_err_single_R8: assert property (@(posedge clk) disable iff (!clr_n)
        frame_err |=> !frame_err);
endmodule

// File: tb/test_aud_deser_rx.sv
module test_aud_deser_rx;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic        long_slot = 1'b0;
    logic        tail_win = 1'b0;
    logic        msb_first = 1'b0;
    logic [15:0] ch1_word;
    logic [15:0] ch2_word;
    logic        pair_valid;
    logic        frame_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp1 [0:255];
    logic [15:0] exp2 [0:255];
    int n_push = 0;
    int n_pop = 0;
    int err_exp = 0;
    int err_seen = 0;
    logic [15:0] last1 = '0;
    logic [15:0] last2 = '0;

    always #2.5 clk = ~clk;

    aud_deser_rx i_aud_deser_rx (
        .clk(clk), .clr_n(clr_n), .lrclk(lrclk), .sdata(sdata),
        .long_slot(long_slot), .tail_win(tail_win), .msb_first(msb_first),
        .ch1_word(ch1_word), .ch2_word(ch2_word),
        .pair_valid(pair_valid), .frame_err(frame_err)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor, just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!clr_n) begin
            last1 = '0;
            last2 = '0;
        end else begin
            check(!(pair_valid && frame_err), "R9 exclusive flags", {pair_valid, frame_err}, 0);
            if (frame_err) err_seen++;
            if (pair_valid) begin
                if (n_pop < n_push) begin
                    check(ch1_word == exp1[n_pop], "R2/R6 ch1 word", ch1_word, exp1[n_pop]);
                    check(ch2_word == exp2[n_pop], "R2/R5 ch2 word", ch2_word, exp2[n_pop]);
                end else begin
                    check(1'b0, "R8/R1 unexpected strobe", n_pop, n_push);
                end
                n_pop++;
                last1 = ch1_word;
                last2 = ch2_word;
            end else begin
                check(ch1_word == last1 && ch2_word == last2, "R7 hold",
                      {ch1_word, ch2_word}, {last1, last2});
            end
        end
    end

    task automatic send_slot(input logic lr, input logic [15:0] w, input int nbits);
        int L;
        int ws;
        L  = long_slot ? 32 : 24;
        ws = tail_win ? L - 16 : 0;
        for (int i = 0; i < nbits; i++) begin
            int   p;
            logic b;
            p = i - ws;
            if (p >= 0 && p < 16) b = msb_first ? w[15 - p] : w[p];
            else                  b = ((i % 3) != 1);
            @(negedge clk);
            lrclk = lr;
            sdata = b;
        end
    endtask

    task automatic good_frame(input logic [15:0] a, input logic [15:0] b);
        int L;
        L = long_slot ? 32 : 24;
        exp1[n_push] = a;
        exp2[n_push] = b;
        n_push++;
        send_slot(1'b1, a, L);
        send_slot(1'b0, b, L);
    endtask

    function automatic logic [15:0] gen_word(input int cfg, input int k);
        case (k)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0001;
            default: return 16'((k * 16'h2F1B + cfg * 16'h0917) ^ 16'h5A3C);
        endcase
    endfunction

    initial begin
        for (int cfg = 0; cfg < 8; cfg++) begin
            int L;
            @(negedge clk);
            clr_n     = 1'b0;
            long_slot = cfg[2];
            tail_win  = cfg[1];
            msb_first = cfg[0];
            L = long_slot ? 32 : 24;
            repeat (4) @(negedge clk);
            // R1: reset state
            check(ch1_word == 0, "R1 ch1 cleared", ch1_word, 0);
            check(ch2_word == 0, "R1 ch2 cleared", ch2_word, 0);
            check(!pair_valid && !frame_err, "R1 flags low", {pair_valid, frame_err}, 0);
            n_pop = n_push;
            err_seen = err_exp;
            clr_n = 1'b1;
            // R1: startup partial slots give no output
            if (cfg[0]) begin
                send_slot(1'b1, 16'h1234, 3);
                send_slot(1'b0, 16'h4321, L);
            end else begin
                send_slot(1'b0, 16'hBEEF, 5);
            end
            check(n_pop == n_push, "R1 no startup output", n_pop, n_push);
            for (int k = 0; k < 10; k++) begin
                logic [15:0] a;
                a = gen_word(cfg, k);
                good_frame(a, {a[7:0], a[15:8]} ^ 16'h0F0F);
            end
            // R8/R4: short channel 1 slot
            send_slot(1'b1, 16'hAAAA, L - 1);
            send_slot(1'b0, 16'h5555, L);
            err_exp++;
            // R8/R4: long channel 2 slot (24-bit config: 25 bits; 32-bit: 33)
            send_slot(1'b1, 16'hC3C3, L);
            send_slot(1'b0, 16'h3C3C, L + 1);
            err_exp++;
            // R8: recovery
            good_frame(16'h0F1E, 16'hE1F0);
            send_slot(1'b1, 16'h0000, 2);
            repeat (3) @(negedge clk);
            check(n_pop == n_push, "R7 all pairs delivered", n_pop, n_push);
            check(err_seen == err_exp, "R8 error pulses", err_seen, err_exp);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule